// File: doc/BRIEF.md
# Barrel shifter with carry-out

This block is the operand shifter of a 32-bit integer datapath. It takes one data word, a three-bit code for the kind of shift, a shift count and the current carry flag. It returns the shifted word and the carry that the shift produces. There are four counted kinds of shift: logical left, logical right, arithmetic right and rotate right. A fifth kind rotates the word one place to the right through the carry flag. Counts of zero, counts equal to the word width and counts above it each follow fixed rules for both the result and the carry.

Register reads, the ALU and flag writeback belong to the surrounding datapath. The block only produces the result and the carry. A parameter selects whether the outputs leave through a register stage, which is the default, or straight from the logic. All four shift kinds share one right-rotator. A left shift by n is done as a rotate right by (width - n) followed by a mask.

Top module: `barrel_carry_shifter`

## Requirements
- R1: The kind input uses these codes: 0 logical left, 1 logical right, 2 arithmetic right, 3 rotate right, 4 one-bit rotate right through the carry.
- R2: Only amount bits [7:0] count. Bits [11:8] of the amount input have no effect on result or carry.
- R3: For codes 0 to 3, a count of zero passes the operand through unchanged and sets carry-out to carry-in.
- R4: Logical left by n (1..31) gives operand << n with carry-out equal to operand bit (32-n). A count of 32 gives result 0 and carry-out equal to operand bit 0. Counts above 32 give result 0 and carry-out 0.
- R5: Logical right by n (1..31) gives operand >> n with carry-out equal to operand bit (n-1). A count of 32 gives result 0 and carry-out equal to operand bit 31. Counts above 32 give result 0 and carry-out 0.
- R6: Arithmetic right by n (1..31) fills the vacated upper bits with bit 31 and sets carry-out to operand bit (n-1). Counts of 32 and above give 32 copies of bit 31 and set carry-out to bit 31.
- R7: Rotate right by a nonzero count rotates by the count modulo 32, and carry-out equals result bit 31.
- R8: Code 4 ignores the count. The result is {carry-in, operand[31:1]} and carry-out is operand bit 0.
- R9: Codes 5, 6 and 7 pass the operand through and set carry-out to carry-in.
- R10: With the output register enabled (default), the outputs show the inputs captured at a rising clock edge from that edge until the next one. An active-low reset clears result and carry-out to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| operand_i | input | 32 | Word to be shifted |
| kind_i | input | 3 | Shift kind code |
| amount_i | input | 12 | Shift count; only bits [7:0] are used |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 32 | Shifted word |
| carry_o | output | 1 | Shifter carry-out |

## Verification
In the default build, the result and carry for a set of inputs are due one cycle after those inputs are applied. They appear just after the rising edge that captures the inputs. The bench changes inputs on the falling edge and compares both outputs on the next falling edge, so exactly one capture edge lies between the stimulus and the check. One directed check reads the outputs just after new inputs are applied and before the capture edge, and confirms they still hold the previous result. Random operands cover every code at every count from 0 to 255, with random upper count bits, and directed cases pin down the width-sized counts.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
   localparam int KIND_W = 3;

   typedef enum logic [KIND_W-1:0] {
      SK_LSL = 3'd0,
      SK_LSR = 3'd1,
      SK_ASR = 3'd2,
      SK_ROR = 3'd3,
      SK_RRX = 3'd4
   } shift_kind_e;
endpackage

// File: rtl/bcs_rotr.sv
// Logarithmic right rotator: one stage per bit of the rotate count.
module bcs_rotr #(
   parameter int W = 32,
   localparam int LGW = $clog2(W)
) (
   input  logic [W-1:0]   data_i,
   input  logic [LGW-1:0] rot_i,
   output logic [W-1:0]   data_o
);
   logic [W-1:0] stg [LGW+1];

   assign stg[0] = data_i;

   for (genvar s = 0; s < LGW; s++) begin : g_stage
      localparam int SH = 1 << s;
      assign stg[s+1] = rot_i[s] ? {stg[s][SH-1:0], stg[s][W-1:SH]} : stg[s];
   end

   assign data_o = stg[LGW];
endmodule

// File: rtl/bcs_decode.sv
// Count decoding: range flags, rotate amount and keep masks.
module bcs_decode
   import bcs_pkg::*;
#(
   parameter int W  = 32,
   parameter int AU = 8,
   localparam int LGW = $clog2(W)
) (
   input  logic [KIND_W-1:0] kind_i,
   input  logic [AU-1:0]     amt_i,
   output logic              zero_o,
   output logic              eq_w_o,
   output logic              ge_w_o,
   output logic [LGW-1:0]    rot_o,
   output logic [W-1:0]      rmask_o,
   output logic [W-1:0]      lmask_o
);
   localparam logic [AU-1:0] W_AMT = AU'(W);

   logic [LGW-1:0] nlow;

   assign nlow   = amt_i[LGW-1:0];
   assign zero_o = (amt_i == '0);
   assign eq_w_o = (amt_i == W_AMT);
   assign ge_w_o = (amt_i >= W_AMT);

   always_comb begin
      if (kind_i == SK_LSL) rot_o = LGW'(0) - nlow;
      else                  rot_o = nlow;
   end

   always_comb begin
      for (int i = 0; i < W; i++) begin
         rmask_o[i] = (i + int'(nlow)) < W;
         lmask_o[i] = i >= int'(nlow);
      end
   end
endmodule

// File: rtl/bcs_select.sv
// Final result and carry selection per shift kind.
module bcs_select
   import bcs_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [W-1:0]      op_i,
   input  logic [KIND_W-1:0] kind_i,
   input  logic              cin_i,
   input  logic [W-1:0]      rot_i,
   input  logic [W-1:0]      rmask_i,
   input  logic [W-1:0]      lmask_i,
   input  logic              zero_i,
   input  logic              eq_w_i,
   input  logic              ge_w_i,
   output logic [W-1:0]      res_o,
   output logic              cout_o
);
   logic sign;
   assign sign = op_i[W-1];

   always_comb begin
      res_o  = op_i;
      cout_o = cin_i;
      case (kind_i)
         SK_LSL: if (!zero_i) begin
            if (ge_w_i) begin
               res_o  = '0;
               cout_o = eq_w_i & rot_i[0];
            end else begin
               res_o  = rot_i & lmask_i;
               cout_o = rot_i[0];
            end
         end
         SK_LSR: if (!zero_i) begin
            if (ge_w_i) begin
               res_o  = '0;
               cout_o = eq_w_i & rot_i[W-1];
            end else begin
               res_o  = rot_i & rmask_i;
               cout_o = rot_i[W-1];
            end
         end
         SK_ASR: if (!zero_i) begin
            if (ge_w_i) begin
               res_o  = {W{sign}};
               cout_o = sign;
            end else begin
               res_o  = (rot_i & rmask_i) | ({W{sign}} & ~rmask_i);
               cout_o = rot_i[W-1];
            end
         end
         SK_ROR: if (!zero_i) begin
            res_o  = rot_i;
            cout_o = rot_i[W-1];
         end
         SK_RRX: begin
            res_o  = {cin_i, op_i[W-1:1]};
            cout_o = op_i[0];
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/barrel_carry_shifter.sv
module barrel_carry_shifter
   import bcs_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int AMT_IN_W  = 12,
   parameter int AMT_USE_W = 8,
   parameter bit REG_OUT   = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [DATA_W-1:0]   operand_i,
   input  logic [KIND_W-1:0]   kind_i,
   input  logic [AMT_IN_W-1:0] amount_i,
   input  logic                carry_i,
   output logic [DATA_W-1:0]   result_o,
   output logic                carry_o
);
   localparam int LGW = $clog2(DATA_W);

   if ((1 << LGW) != DATA_W || DATA_W < 2) begin : g_bad_width
      $error("DATA_W must be a power of two of at least 2");
   end
   if (AMT_USE_W <= LGW) begin : g_bad_use
      $error("AMT_USE_W must be able to hold DATA_W");
   end
   if (AMT_IN_W < AMT_USE_W) begin : g_bad_in
      $error("AMT_IN_W must not be narrower than AMT_USE_W");
   end

   logic [AMT_USE_W-1:0] amt;
   logic                 zero, eq_w, ge_w;
   logic [LGW-1:0]       rot_amt;
   logic [DATA_W-1:0]    rmask, lmask, rotated, res_c;
   logic                 cout_c;

   assign amt = amount_i[AMT_USE_W-1:0];

   if (AMT_IN_W > AMT_USE_W) begin : g_hi
      logic unused_amt_hi;
      assign unused_amt_hi = ^amount_i[AMT_IN_W-1:AMT_USE_W];
   end

   bcs_decode #(.W(DATA_W), .AU(AMT_USE_W)) u_dec (
      .kind_i (kind_i),
      .amt_i  (amt),
      .zero_o (zero),
      .eq_w_o (eq_w),
      .ge_w_o (ge_w),
      .rot_o  (rot_amt),
      .rmask_o(rmask),
      .lmask_o(lmask)
   );

   bcs_rotr #(.W(DATA_W)) u_rot (
      .data_i(operand_i),
      .rot_i (rot_amt),
      .data_o(rotated)
   );

   bcs_select #(.W(DATA_W)) u_sel (
      .op_i   (operand_i),
      .kind_i (kind_i),
      .cin_i  (carry_i),
      .rot_i  (rotated),
      .rmask_i(rmask),
      .lmask_i(lmask),
      .zero_i (zero),
      .eq_w_i (eq_w),
      .ge_w_i (ge_w),
      .res_o  (res_c),
      .cout_o (cout_c)
   );

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            result_o <= '0;
            carry_o  <= 1'b0;
         end else begin
            result_o <= res_c;
            carry_o  <= cout_c;
         end
      end
   end else begin : g_comb
      logic unused_clkrst;
      assign unused_clkrst = clk ^ rst_n;
      assign result_o = res_c;
      assign carry_o  = cout_c;
   end
endmodule

// File: rtl/bcs_chk.sv
module bcs_chk #(
   parameter int W       = 32,
   parameter int AIN     = 12,
   parameter int AU      = 8,
   parameter bit REG_OUT = 1'b1
) (
   input logic           clk,
   input logic           rst_n,
   input logic [W-1:0]   operand_i,
   input logic [2:0]     kind_i,
   input logic [AIN-1:0] amount_i,
   input logic           carry_i,
   input logic [W-1:0]   result_o,
   input logic           carry_o
);
   localparam logic [AU-1:0] W_AMT = AU'(W);

   logic [AU-1:0] n;
   assign n = amount_i[AU-1:0];

   if (REG_OUT) begin : g_props
      assert_zero_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (kind_i < 3'd4 && n == '0) |=>
         (result_o == $past(operand_i) && carry_o == $past(carry_i)));

      assert_lsl_over_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (kind_i == 3'd0 && n > W_AMT) |=> (result_o == '0 && !carry_o));

      assert_asr_sat_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (kind_i == 3'd2 && n >= W_AMT) |=>
         (result_o == {W{$past(operand_i[W-1])}} && carry_o == $past(operand_i[W-1])));

      assert_ror_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (kind_i == 3'd3 && n != '0) |=> (carry_o == result_o[W-1]));

      assert_rrx_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (kind_i == 3'd4) |=>
         (result_o == {$past(carry_i), $past(operand_i[W-1:1])} && carry_o == $past(operand_i[0])));

      assert_unused_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (kind_i > 3'd4) |=>
         (result_o == $past(operand_i) && carry_o == $past(carry_i)));
   end
endmodule

bind barrel_carry_shifter bcs_chk #(
   .W(DATA_W), .AIN(AMT_IN_W), .AU(AMT_USE_W), .REG_OUT(REG_OUT)
) chk_i (.*);

// File: tb/barrel_carry_shifter_tb_top.sv
`timescale 1ns/1ps
module barrel_carry_shifter_tb_top;
   localparam int W   = 32;
   localparam int AIN = 12;
   localparam int AU  = 8;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [W-1:0]   operand_i = '0;
   logic [2:0]     kind_i = '0;
   logic [AIN-1:0] amount_i = '0;
   logic           carry_i = 1'b0;
   logic [W-1:0]   result_o;
   logic           carry_o;

   int n_chk = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   barrel_carry_shifter dut_i (
      .clk(clk), .rst_n(rst_n), .operand_i(operand_i), .kind_i(kind_i),
      .amount_i(amount_i), .carry_i(carry_i), .result_o(result_o), .carry_o(carry_o)
   );

   // Expected {carry, result} from the requirements.
   function automatic logic [W:0] model(logic [W-1:0] op, logic [2:0] k,
                                        logic [AIN-1:0] a, logic c);
      int n = int'(a[AU-1:0]);
      int m;
      logic [W-1:0] r = op;
      logic co = c;
      case (k)
         3'd0: if (n > 0) begin
            if (n < W)       begin r = op << n; co = op[W-n]; end
            else if (n == W) begin r = '0; co = op[0]; end
            else             begin r = '0; co = 1'b0; end
         end
         3'd1: if (n > 0) begin
            if (n < W)       begin r = op >> n; co = op[n-1]; end
            else if (n == W) begin r = '0; co = op[W-1]; end
            else             begin r = '0; co = 1'b0; end
         end
         3'd2: if (n > 0) begin
            if (n < W) begin r = W'($signed(op) >>> n); co = op[n-1]; end
            else       begin r = {W{op[W-1]}}; co = op[W-1]; end
         end
         3'd3: if (n > 0) begin
            m = n % W;
            if (m != 0) r = (op >> m) | (op << (W - m));
            co = r[W-1];
         end
         3'd4: begin r = {c, op[W-1:1]}; co = op[0]; end
         default: ;
      endcase
      return {co, r};
   endfunction

   task automatic check(string req, logic [W-1:0] er, logic ec);
      n_chk++;
      if (result_o !== er || carry_o !== ec) begin
         n_fail++;
         $display("FAIL %s: result=%h carry=%b expected result=%h carry=%b",
                  req, result_o, carry_o, er, ec);
      end
   endtask

   task automatic run(string req, logic [W-1:0] op, logic [2:0] k,
                      logic [AIN-1:0] a, logic c);
      logic [W:0] e;
      @(negedge clk);
      operand_i = op; kind_i = k; amount_i = a; carry_i = c;
      @(negedge clk);
      e = model(op, k, a, c);
      check(req, e[W-1:0], e[W]);
   endtask

   task automatic run_fixed(string req, logic [W-1:0] op, logic [2:0] k,
                            logic [AIN-1:0] a, logic c, logic [W-1:0] er, logic ec);
      @(negedge clk);
      operand_i = op; kind_i = k; amount_i = a; carry_i = c;
      @(negedge clk);
      check(req, er, ec);
   endtask

   function automatic string req_of(logic [2:0] k, int n);
      if (k < 3'd4 && n == 0) return "R3";
      case (k)
         3'd0: return "R4";
         3'd1: return "R5";
         3'd2: return "R6";
         3'd3: return "R7";
         3'd4: return "R8";
         default: return "R9";
      endcase
   endfunction

   initial begin
      #(4 * 200000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [W-1:0] op;
      logic [W-1:0] hi;
      logic [W-1:0] seed_r;
      seed_r = $urandom(32'h1F2E3D4C);
      operand_i = seed_r;

      // R10 reset state
      @(negedge clk);
      @(negedge clk);
      check("R10", '0, 1'b0);
      rst_n = 1'b1;

      // R1 encoding of logical left
      run_fixed("R1", 32'h8000_0001, 3'd0, 12'h001, 1'b0, 32'h0000_0002, 1'b1);
      // R8 amount ignored
      run_fixed("R8", 32'h0000_0003, 3'd4, 12'h007, 1'b1, 32'h8000_0001, 1'b1);
      // R2 upper count bits ignored
      run_fixed("R2", 32'h0000_1234, 3'd0, 12'hF00, 1'b1, 32'h0000_1234, 1'b1);
      run_fixed("R2", 32'h0000_1234, 3'd1, 12'h101, 1'b1, 32'h0000_091A, 1'b0);
      // width-sized and larger counts
      run_fixed("R4", 32'h0000_0001, 3'd0, 12'h020, 1'b0, 32'h0, 1'b1);
      run_fixed("R4", 32'hFFFF_FFFF, 3'd0, 12'h021, 1'b1, 32'h0, 1'b0);
      run_fixed("R5", 32'h8000_0000, 3'd1, 12'h020, 1'b0, 32'h0, 1'b1);
      run_fixed("R5", 32'hFFFF_FFFF, 3'd1, 12'h0FF, 1'b1, 32'h0, 1'b0);
      run_fixed("R6", 32'h8000_0000, 3'd2, 12'h020, 1'b0, 32'hFFFF_FFFF, 1'b1);
      run_fixed("R6", 32'h7FFF_FFFF, 3'd2, 12'h0C8, 1'b1, 32'h0, 1'b0);
      run_fixed("R7", 32'h8000_0000, 3'd3, 12'h020, 1'b0, 32'h8000_0000, 1'b1);
      run_fixed("R7", 32'h0000_0001, 3'd3, 12'h040, 1'b1, 32'h0000_0001, 1'b0);
      run_fixed("R9", 32'hCAFE_F00D, 3'd6, 12'h003, 1'b1, 32'hCAFE_F00D, 1'b1);

      // R10 output holds until the capture edge
      @(negedge clk);
      operand_i = 32'h1; kind_i = 3'd0; amount_i = 12'h004; carry_i = 1'b0;
      #1;
      check("R10", 32'hCAFE_F00D, 1'b1);
      @(negedge clk);
      check("R10", 32'h0000_0010, 1'b0);

      // every code at every count, random operands and upper count bits
      for (int k = 0; k < 8; k++) begin
         for (int a = 0; a < 256; a++) begin
            op = $urandom;
            hi = $urandom;
            if (a % 5 == 0) op[W-1] = 1'b1;
            run(req_of(3'(k), a), op, 3'(k), {hi[AIN-AU-1:0], 8'(a)}, 1'($urandom));
         end
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule